// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt events for a register-mapped peripheral into a sixteen-bit sticky status word and raises one active-high interrupt line whenever a latched event is not masked. Internal event sources (periodic clock tick, alarm match, rejected clock update and so on) arrive as single-cycle pulses, one pulse line per status bit. A power-button level input is sampled and only its rising edge is turned into an event.

Software sees the block through byte-wide registers on a simple synchronous write strobe and a combinational read port. Both the mask and the status have a low-byte and a high-byte register. Clearing is done through two separate write-one-to-clear acknowledge registers, so that a read of the status never changes it. The interrupt output is taken from a flop and follows the status and mask one clock later.

Top module: `irqc_top`

## Requirements
- R1: After reset the status reads 0x0000, the mask reads 0x0FFF (low byte 0xFF at offset 0, high byte 0x0F at offset 1) and `irq_out` is low.
- R2: A write to offset 0 replaces mask bits 7:0 and a write to offset 1 replaces mask bits 15:8; the other half keeps its value.
- R3: A pulse on `evt_pulse[i]` sets status bit i at the next clock, and the bit stays set until acknowledged. Bit 8 is the periodic clock tick, bit 9 the alarm and bit 10 the rejected clock update. Status bits 7:0 read at offset 2 and bits 15:8 at offset 3.
- R4: Writing a byte to offset 4 clears every status bit 7:0 that has a 1 in the byte; writing to offset 5 does the same for bits 15:8. Status bits at a 0 in the byte are kept.
- R5: Offsets 4 and 5 read as 0x00, as does every offset above 5.
- R6: Writes to the status offsets 2 and 3 leave the status unchanged.
- R7: `irq_out` is high exactly when, in the previous cycle, some status bit was set with its mask bit clear; it changes one clock after the status or mask change that causes it.
- R8: A low-to-high transition of `pwr_btn` sets status bit 11. Holding it high or dropping it sets nothing.
- R9: When an event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | ADDR_W (4) | Register offset for reads and writes |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read byte for `reg_addr` |
| evt_pulse | input | 16 | Single-cycle event pulses, bit i sets status bit i |
| pwr_btn | input | 1 | Power-button level, rising edge sets status bit 11 |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A register write or an event pulse lands in the status or mask at the clock edge that samples it, so the bench reads those back on the next falling edge; a rising button level applied at a falling edge also appears after that single edge. The interrupt line carries one more flop, so every interrupt check first confirms the old level on the falling edge right after the causing edge and then the new level one full cycle later. All stimulus is driven on falling edges and all sampling happens one nanosecond after a falling edge, well clear of the rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SRC_W  = 2 * BYTE_W;

    // register offsets; low and high halves are adjacent
    localparam int unsigned OFS_MASK_LO = 0;
    localparam int unsigned OFS_MASK_HI = 1;
    localparam int unsigned OFS_STAT_LO = 2;
    localparam int unsigned OFS_STAT_HI = 3;
    localparam int unsigned OFS_ACK_LO  = 4;
    localparam int unsigned OFS_ACK_HI  = 5;

    // status bit assignment
    localparam int unsigned BIT_TICK    = 8;
    localparam int unsigned BIT_ALARM   = 9;
    localparam int unsigned BIT_UPD_ERR = 10;
    localparam int unsigned BIT_BUTTON  = 11;

    localparam logic [SRC_W-1:0] MASK_RESET = 16'h0FFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_LO,
        SEL_MASK_HI,
        SEL_STAT_LO,
        SEL_STAT_HI,
        SEL_ACK_LO,
        SEL_ACK_HI
    } reg_sel_e;

    typedef struct packed {
        logic mask_lo;
        logic mask_hi;
        logic ack_lo;
        logic ack_hi;
    } wr_strobe_t;

    function automatic reg_sel_e decode_offset(input int unsigned ofs);
        case (ofs)
            OFS_MASK_LO: return SEL_MASK_LO;
            OFS_MASK_HI: return SEL_MASK_HI;
            OFS_STAT_LO: return SEL_STAT_LO;
            OFS_STAT_HI: return SEL_STAT_HI;
            OFS_ACK_LO:  return SEL_ACK_LO;
            OFS_ACK_HI:  return SEL_ACK_HI;
            default:     return SEL_NONE;
        endcase
    endfunction

    // place a byte in the low or high half of a status-wide word
    function automatic logic [SRC_W-1:0] lane_place(input logic [BYTE_W-1:0] b,
                                                    input logic hi);
        return hi ? {b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, b};
    endfunction

endpackage

// File: rtl/irqc_rise_det.sv
module irqc_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;

    // a held-high level yields a single event
    p_single_rise_r8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wr_byte,
    output logic [W-1:0]   mask_q
);
    localparam int unsigned HALF = W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= RESET_VAL;
        end else begin
            if (wr_lo) mask_q[HALF-1:0] <= wr_byte;
            if (wr_hi) mask_q[W-1:HALF] <= wr_byte;
        end
    end

    p_mask_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> mask_q[W-1:HALF] == $past(mask_q[W-1:HALF]));
    p_mask_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> mask_q[HALF-1:0] == $past(mask_q[HALF-1:0]));

endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status_q
);
    logic [W-1:0] status_d;

    // set has priority over clear on the same bit
    always_comb status_d = (status_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    p_set_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> (status_q & $past(set_vec)) == $past(set_vec));
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> (status_q & $past(clr_vec & ~set_vec)) == '0);
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0 && clr_vec == '0) |=> $stable(status_q));

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [irqc_pkg::BYTE_W-1:0] wr_data,
    output logic [irqc_pkg::BYTE_W-1:0] rd_data,
    input  logic [irqc_pkg::SRC_W-1:0]  evt_pulse,
    input  logic                        pwr_btn,
    output logic                        irq_out
);
    import irqc_pkg::*;

    reg_sel_e           sel;
    wr_strobe_t         stb;
    logic               btn_rise;
    logic [SRC_W-1:0]   set_vec;
    logic [SRC_W-1:0]   clr_vec;
    logic [SRC_W-1:0]   status_q;
    logic [SRC_W-1:0]   mask_q;
    logic               irq_q;

    assign sel = decode_offset(int'(reg_addr));

    always_comb begin
        stb         = '0;
        stb.mask_lo = wr_en && (sel == SEL_MASK_LO);
        stb.mask_hi = wr_en && (sel == SEL_MASK_HI);
        stb.ack_lo  = wr_en && (sel == SEL_ACK_LO);
        stb.ack_hi  = wr_en && (sel == SEL_ACK_HI);
    end

    irqc_rise_det u_btn (
        .clk   (clk),
        .rst   (rst),
        .level (pwr_btn),
        .rise  (btn_rise)
    );

    always_comb begin
        set_vec = evt_pulse | (SRC_W'(btn_rise) << BIT_BUTTON);
        clr_vec = '0;
        if (stb.ack_lo) clr_vec = lane_place(wr_data, 1'b0);
        if (stb.ack_hi) clr_vec = lane_place(wr_data, 1'b1);
    end

    irqc_status_bank #(.W(SRC_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .status_q (status_q)
    );

    irqc_mask_bank #(.W(SRC_W), .RESET_VAL(MASK_RESET)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (stb.mask_lo),
        .wr_hi   (stb.mask_hi),
        .wr_byte (wr_data),
        .mask_q  (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status_q & ~mask_q);
    end

    assign irq_out = irq_q;

    always_comb begin
        case (sel)
            SEL_MASK_LO: rd_data = mask_q[BYTE_W-1:0];
            SEL_MASK_HI: rd_data = mask_q[SRC_W-1:BYTE_W];
            SEL_STAT_LO: rd_data = status_q[BYTE_W-1:0];
            SEL_STAT_HI: rd_data = status_q[SRC_W-1:BYTE_W];
            default:     rd_data = '0;
        endcase
    end

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |=> !irq_out);
    p_irq_all_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |=> !irq_out);
    p_button_sets_r8: assert property (@(posedge clk) disable iff (rst)
        btn_rise |=> status_q[BIT_BUTTON]);

endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] evt_pulse = '0;
    logic        pwr_btn = 1'b0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top #(.ADDR_W(4)) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .evt_pulse (evt_pulse),
        .pwr_btn   (pwr_btn),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int ofs, input int val);
        reg_addr = 4'(ofs);
        wr_data  = 8'(val);
        wr_en    = 1'b1;
        step();
        wr_en    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int ofs, input int exp);
        reg_addr = 4'(ofs);
        #0.5;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic pulse(input logic [15:0] v);
        evt_pulse = v;
        step();
        evt_pulse = '0;
    endtask

    task automatic t_reset_state();
        rd_chk("R1 mask lo", 0, 8'hFF);
        rd_chk("R1 mask hi", 1, 8'h0F);
        rd_chk("R1 stat lo", 2, 0);
        rd_chk("R1 stat hi", 3, 0);
        chk("R1 irq", int'(irq_out), 0);
    endtask

    task automatic t_read_zero();
        rd_chk("R5 ack lo reads 0", 4, 0);
        rd_chk("R5 ack hi reads 0", 5, 0);
        rd_chk("R5 unmapped 6", 6, 0);
        rd_chk("R5 unmapped 15", 15, 0);
    endtask

    task automatic t_event_sticky();
        pulse(16'h0100);                       // periodic tick, bit 8
        rd_chk("R3 tick latched", 3, 8'h01);
        step(); step(); step();
        rd_chk("R3 tick sticky", 3, 8'h01);
        chk("R7 masked tick no irq", int'(irq_out), 0);
    endtask

    task automatic t_mask_halves();
        wr(1, 8'h0E);                          // unmask bit 8
        rd_chk("R2 hi replaced", 1, 8'h0E);
        rd_chk("R2 lo kept", 0, 8'hFF);
        chk("R7 irq not yet", int'(irq_out), 0);
        step();
        chk("R7 irq one clock later", int'(irq_out), 1);
        wr(0, 8'h5A);
        rd_chk("R2 lo replaced", 0, 8'h5A);
        rd_chk("R2 hi kept", 1, 8'h0E);
        wr(0, 8'hFF);
    endtask

    task automatic t_ack();
        wr(5, 8'h01);
        rd_chk("R4 hi ack clears tick", 3, 0);
        chk("R7 irq holds one clock", int'(irq_out), 1);
        step();
        chk("R7 irq drops", int'(irq_out), 0);
        pulse(16'h0009);
        rd_chk("R3 low bits set", 2, 8'h09);
        wr(4, 8'h01);
        rd_chk("R4 only acked bit cleared", 2, 8'h08);
        wr(5, 8'hFF);
        rd_chk("R4 hi ack leaves low half", 2, 8'h08);
        wr(4, 8'h08);
        rd_chk("R4 low cleared", 2, 0);
    endtask

    task automatic t_status_write_ignored();
        pulse(16'h0200);                       // alarm, bit 9
        wr(3, 8'h00);
        rd_chk("R6 status hi write ignored", 3, 8'h02);
        wr(2, 8'hFF);
        rd_chk("R6 status lo write ignored", 2, 0);
        wr(5, 8'h02);
        rd_chk("R4 alarm acked", 3, 0);
    endtask

    task automatic t_low_source_irq();
        wr(0, 8'hFB);                          // unmask bit 2
        pulse(16'h0004);
        chk("R7 irq lags event", int'(irq_out), 0);
        step();
        chk("R7 irq from low source", int'(irq_out), 1);
        wr(0, 8'hFF);
        chk("R7 irq lags mask", int'(irq_out), 1);
        step();
        chk("R7 remasked irq low", int'(irq_out), 0);
        wr(4, 8'h04);
    endtask

    task automatic t_button();
        pwr_btn = 1'b1;
        step();
        rd_chk("R8 rising edge sets bit 11", 3, 8'h08);
        wr(5, 8'h08);
        rd_chk("R8 acked", 3, 0);
        step(); step();
        rd_chk("R8 steady high no event", 3, 0);
        pwr_btn = 1'b0;
        step(); step();
        rd_chk("R8 falling edge no event", 3, 0);
        pwr_btn = 1'b1;
        step();
        rd_chk("R8 second rise sets again", 3, 8'h08);
        pwr_btn = 1'b0;
        wr(5, 8'h08);
    endtask

    task automatic t_collision();
        evt_pulse = 16'h0400;                  // rejected update, bit 10
        wr(5, 8'h04);
        evt_pulse = '0;
        rd_chk("R9 event beats ack", 3, 8'h04);
        wr(5, 8'h04);
        rd_chk("R9 later ack clears", 3, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state();
        t_read_zero();
        t_event_sticky();
        t_mask_halves();
        t_ack();
        t_status_write_ignored();
        t_low_source_irq();
        t_button();
        t_collision();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule